// File: doc/BRIEF.md
# Boundary-Detecting Serial Word Receiver

This block takes a source-synchronous serial link made of a bit clock line and a data line, samples both with a fast system clock, and rebuilds parallel words. Both edges of the bit clock carry a data bit, so each change of the sampled bit clock shifts one data bit in. Words are delimited by a pattern that never appears inside a word: the bit clock is held high for more than one bit slot while the data line changes. When that pattern is seen and exactly 24 bits arrived since the previous boundary, the word is accepted. Its first 20 bits drive the shared parallel outputs, bits 21 and 22 drive the two dedicated outputs, and bits 23 and 24 are discarded.

For each accepted word the block also produces a word clock that idles high. It falls a fixed number of bit slots after the update and stays low for 13 bit slots. Words with the wrong bit count are dropped without a pulse, and filler driven on the data line while the bit clock rests after a boundary is ignored. Pulling the enable input low clears the word state and forces the outputs to their idle values. The input samplers keep running while enable is low, so a held bit clock level is not mistaken for an edge when enable returns.

Top module: `wordsync_deser`

## Requirements
- R1: While `en_i` is low, and after reset, `shared_o` and `ded_o` are all zero and `wclk_o` is high.
- R2: Every change of the sampled bit clock, rising or falling, captures one data bit. In an accepted word, the k-th bit received (k counted from 1) drives `shared_o[k-1]` for k from 1 to 20, and `ded_o[k-21]` for k of 21 and 22. Bits 23 and 24 drive no output.
- R3: A boundary is a change of the data line while the bit clock is high and has not changed for at least SLOT_CYC sampled cycles. Only the first such change after a bit clock edge counts. Data changes at ordinary bit slot starts are not boundaries.
- R4: The parallel outputs change only when a word is accepted or `en_i` is low. Between accepted words they hold their values.
- R5: A boundary that follows a bit count other than 24 drops the word. The outputs keep their previous values, no word clock pulse follows, and counting restarts from zero.
- R6: After an accepted word, `wclk_o` goes low SYNC_STAGES+1+6*SLOT_CYC cycles after the data change at `sdat_i` that marks the boundary. It stays low for exactly 13*SLOT_CYC cycles and then returns high.
- R7: If no boundary is seen, no pulse is produced and `wclk_o` stays high. A word of 24 bits sent without a boundary makes the next word's count exceed 24, so that word is dropped as well.
- R8: Filler values driven on `sdat_i` while the bit clock rests high after a boundary change no outputs and produce no pulse.
- R9: Pulling `en_i` low in the middle of a word discards the bits already received. The first full word after `en_i` returns high is accepted.
- R10: The parallel outputs take a new word SYNC_STAGES+1 cycles after the boundary data change at `sdat_i`, and not earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Oversampling system clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Enable; low clears word state and forces idle outputs |
| bclk_i | input | 1 | Serial bit clock, both edges carry a bit |
| sdat_i | input | 1 | Serial data |
| shared_o | output | 20 | Received bits 1 to 20 of the last accepted word |
| ded_o | output | 2 | Received bits 21 and 22 of the last accepted word |
| wclk_o | output | 1 | Word clock, idles high, one low pulse per accepted word |

## Verification
A bit counter that drifts by one edge makes the next boundary fail the exact-count test. The outputs then freeze on the previous word and the word clock stays high, which is visible within one word period of about 26 bit slots. A hold threshold that is too short turns an ordinary data change into a boundary, so the outputs take a partial word in the middle of a frame. A threshold that is too long, or a word clock timer that is off by one, moves the falling or rising edge of the pulse by cycles. That shift is visible on the first accepted word after reset. Filler on the data line and an enable drop in the middle of a word are driven deliberately, because an arming flag or count that is not cleared would only show as one wrongly accepted or dropped word.

// File: rtl/wsd_pkg.sv
package wsd_pkg;

  localparam int DEF_SYNC_STAGES = 2;
  localparam int DEF_SLOT_CYC    = 8;
  localparam int DEF_WORD_BITS   = 24;
  localparam int DEF_SHARED_BITS = 20;
  localparam int DEF_DED_BITS    = 2;
  localparam int DEF_FALL_SLOTS  = 6;
  localparam int DEF_LOW_SLOTS   = 13;

  typedef enum logic [1:0] {
    WC_IDLE = 2'd0,
    WC_WAIT = 2'd1,
    WC_LOW  = 2'd2
  } wc_state_e;

endpackage

// File: rtl/wsd_link_sampler.sv
module wsd_link_sampler #(
  parameter int SYNC_STAGES = wsd_pkg::DEF_SYNC_STAGES
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bclk_i,
  input  logic sdat_i,
  output logic bclk_s_o,
  output logic dat_s_o,
  output logic edge_o,
  output logic dchg_o
);

  localparam int MSB = SYNC_STAGES - 1;

  logic [MSB:0] bq, dq, bq_nx, dq_nx;
  logic         bprev_q, dprev_q;

  // Both lines pass through the same number of stages so that the
  // data sampled at a clock edge stays aligned with that edge.
  generate
    if (SYNC_STAGES > 1) begin : g_chain
      assign bq_nx = {bq[MSB-1:0], bclk_i};
      assign dq_nx = {dq[MSB-1:0], sdat_i};
    end else begin : g_single
      assign bq_nx = bclk_i;
      assign dq_nx = sdat_i;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bq      <= '0;
      dq      <= '0;
      bprev_q <= 1'b0;
      dprev_q <= 1'b0;
    end else begin
      bq      <= bq_nx;
      dq      <= dq_nx;
      bprev_q <= bq[MSB];
      dprev_q <= dq[MSB];
    end
  end

  assign bclk_s_o = bq[MSB];
  assign dat_s_o  = dq[MSB];
  assign edge_o   = bq[MSB] ^ bprev_q;
  assign dchg_o   = dq[MSB] ^ dprev_q;

endmodule

// File: rtl/wsd_frame_tracker.sv
module wsd_frame_tracker #(
  parameter int WORD_BITS = wsd_pkg::DEF_WORD_BITS,
  parameter int KEEP_BITS = wsd_pkg::DEF_SHARED_BITS + wsd_pkg::DEF_DED_BITS,
  parameter int SLOT_CYC  = wsd_pkg::DEF_SLOT_CYC
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 en_i,
  input  logic                 bclk_s_i,
  input  logic                 dat_s_i,
  input  logic                 edge_i,
  input  logic                 dchg_i,
  output logic                 wv_o,
  output logic [KEEP_BITS-1:0] word_o
);

  localparam int CW      = $clog2(WORD_BITS + 2);
  localparam int HW      = $clog2(SLOT_CYC + 1);
  localparam int CNT_SAT = WORD_BITS + 1;

  logic [WORD_BITS-1:0] sh_q, sh_nx;
  logic [CW-1:0]        cnt_q, cnt_nx;
  logic [HW-1:0]        hold_q, hold_nx;
  logic                 armed_q, armed_nx;
  logic                 long_high, bnd;

  assign long_high = (hold_q == HW'(SLOT_CYC));
  assign bnd = en_i && armed_q && bclk_s_i && !edge_i && dchg_i && long_high;

  always_comb begin
    hold_nx  = hold_q;
    armed_nx = armed_q;
    cnt_nx   = cnt_q;
    sh_nx    = sh_q;
    if (!en_i) begin
      hold_nx  = '0;
      armed_nx = 1'b0;
      cnt_nx   = '0;
      sh_nx    = '0;
    end else if (edge_i) begin
      hold_nx  = '0;
      armed_nx = 1'b1;
      sh_nx    = {sh_q[WORD_BITS-2:0], dat_s_i};
      if (cnt_q != CW'(CNT_SAT)) cnt_nx = cnt_q + 1'b1;
    end else begin
      if (bclk_s_i && !long_high) hold_nx = hold_q + 1'b1;
      if (bnd) begin
        armed_nx = 1'b0;
        cnt_nx   = '0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q  <= '0;
      armed_q <= 1'b0;
      cnt_q   <= '0;
      sh_q    <= '0;
    end else begin
      hold_q  <= hold_nx;
      armed_q <= armed_nx;
      cnt_q   <= cnt_nx;
      sh_q    <= sh_nx;
    end
  end

  assign wv_o   = bnd && (cnt_q == CW'(WORD_BITS));
  assign word_o = sh_q[WORD_BITS-1 -: KEEP_BITS];

  // R3
  single_bnd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bnd |=> !bnd);

  // R5
  cnt_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bnd |=> (cnt_q == '0));

endmodule

// File: rtl/wsd_wordclk_gen.sv
module wsd_wordclk_gen #(
  parameter int FALL_CYC = 48,
  parameter int LOW_CYC  = 104
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic wv_i,
  output logic wclk_o
);

  import wsd_pkg::*;

  localparam int MAXC = (FALL_CYC > LOW_CYC) ? FALL_CYC : LOW_CYC;
  localparam int TW   = $clog2(MAXC + 1);

  wc_state_e     st_q, st_nx;
  logic [TW-1:0] t_q, t_nx;

  always_comb begin
    st_nx = st_q;
    t_nx  = t_q;
    if (!en_i) begin
      st_nx = WC_IDLE;
      t_nx  = '0;
    end else if (wv_i) begin
      st_nx = WC_WAIT;
      t_nx  = '0;
    end else begin
      unique case (st_q)
        WC_WAIT: begin
          if (t_q == TW'(FALL_CYC - 1)) begin
            st_nx = WC_LOW;
            t_nx  = '0;
          end else begin
            t_nx = t_q + 1'b1;
          end
        end
        WC_LOW: begin
          if (t_q == TW'(LOW_CYC - 1)) begin
            st_nx = WC_IDLE;
            t_nx  = '0;
          end else begin
            t_nx = t_q + 1'b1;
          end
        end
        default: begin
          st_nx = WC_IDLE;
          t_nx  = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= WC_IDLE;
      t_q  <= '0;
    end else begin
      st_q <= st_nx;
      t_q  <= t_nx;
    end
  end

  assign wclk_o = (st_q != WC_LOW);

  // Checker state: length of the current low phase of the output.
  localparam int RW = $clog2(LOW_CYC + 2);
  logic [RW-1:0] low_run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      low_run_q <= '0;
    end else if (wclk_o) begin
      low_run_q <= '0;
    end else if (low_run_q != RW'(LOW_CYC + 1)) begin
      low_run_q <= low_run_q + 1'b1;
    end
  end

  // R6
  low_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || !en_i)
    ($rose(wclk_o) && !$past(wv_i)) |-> (low_run_q == RW'(LOW_CYC)));

endmodule

// File: rtl/wordsync_deser.sv
module wordsync_deser #(
  parameter int SYNC_STAGES = wsd_pkg::DEF_SYNC_STAGES,
  parameter int SLOT_CYC    = wsd_pkg::DEF_SLOT_CYC,
  parameter int WORD_BITS   = wsd_pkg::DEF_WORD_BITS,
  parameter int SHARED_BITS = wsd_pkg::DEF_SHARED_BITS,
  parameter int DED_BITS    = wsd_pkg::DEF_DED_BITS,
  parameter int FALL_SLOTS  = wsd_pkg::DEF_FALL_SLOTS,
  parameter int LOW_SLOTS   = wsd_pkg::DEF_LOW_SLOTS
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   en_i,
  input  logic                   bclk_i,
  input  logic                   sdat_i,
  output logic [SHARED_BITS-1:0] shared_o,
  output logic [DED_BITS-1:0]    ded_o,
  output logic                   wclk_o
);

  localparam int KEEP_BITS = SHARED_BITS + DED_BITS;
  localparam int FALL_CYC  = FALL_SLOTS * SLOT_CYC;
  localparam int LOW_CYC   = LOW_SLOTS * SLOT_CYC;

  logic                 bclk_s, dat_s, bedge, dchg, wv;
  logic [KEEP_BITS-1:0] word;

  wsd_link_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_smp (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .bclk_i   (bclk_i),
    .sdat_i   (sdat_i),
    .bclk_s_o (bclk_s),
    .dat_s_o  (dat_s),
    .edge_o   (bedge),
    .dchg_o   (dchg)
  );

  wsd_frame_tracker #(
    .WORD_BITS (WORD_BITS),
    .KEEP_BITS (KEEP_BITS),
    .SLOT_CYC  (SLOT_CYC)
  ) u_trk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en_i),
    .bclk_s_i (bclk_s),
    .dat_s_i  (dat_s),
    .edge_i   (bedge),
    .dchg_i   (dchg),
    .wv_o     (wv),
    .word_o   (word)
  );

  wsd_wordclk_gen #(.FALL_CYC(FALL_CYC), .LOW_CYC(LOW_CYC)) u_wck (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .wv_i   (wv),
    .wclk_o (wclk_o)
  );

  // Position mapping: the first bit received sits at word[KEEP_BITS-1].
  logic [SHARED_BITS-1:0] sh_map;
  logic [DED_BITS-1:0]    dd_map;

  generate
    for (genvar i = 0; i < SHARED_BITS; i++) begin : g_shared
      assign sh_map[i] = word[KEEP_BITS-1-i];
    end
    for (genvar j = 0; j < DED_BITS; j++) begin : g_ded
      assign dd_map[j] = word[KEEP_BITS-1-SHARED_BITS-j];
    end
  endgenerate

  logic [SHARED_BITS-1:0] shared_q, shared_nx;
  logic [DED_BITS-1:0]    ded_q, ded_nx;

  always_comb begin
    shared_nx = shared_q;
    ded_nx    = ded_q;
    if (!en_i) begin
      shared_nx = '0;
      ded_nx    = '0;
    end else if (wv) begin
      shared_nx = sh_map;
      ded_nx    = dd_map;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shared_q <= '0;
      ded_q    <= '0;
    end else begin
      shared_q <= shared_nx;
      ded_q    <= ded_nx;
    end
  end

  assign shared_o = shared_q;
  assign ded_o    = ded_q;

  // Checker state: an accepted word has been seen since enable.
  logic seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     seen_q <= 1'b0;
    else if (!en_i)  seen_q <= 1'b0;
    else if (wv)     seen_q <= 1'b1;
  end

  // R4
  out_change_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(shared_q) || !$stable(ded_q)) |-> ($past(wv) || !$past(en_i)));

  // R1
  idle_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (shared_o == '0 && ded_o == '0 && wclk_o));

  // R7
  no_word_no_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wclk_o |-> seen_q);

endmodule

// File: tb/wordsync_deser_tb.sv
module wordsync_deser_tb_top;

  localparam int SLOT   = 8;
  localparam int HALF   = SLOT / 2;
  localparam int LAT    = 3;
  localparam int FALL_C = 6 * SLOT;
  localparam int LOW_C  = 13 * SLOT;

  logic        clk = 1'b0;
  logic        rst_n, en, bclk, sdat;
  logic [19:0] shared;
  logic [1:0]  ded;
  logic        wclk;

  always #5 clk = ~clk;

  wordsync_deser dut_i (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .en_i     (en),
    .bclk_i   (bclk),
    .sdat_i   (sdat),
    .shared_o (shared),
    .ded_o    (ded),
    .wclk_o   (wclk)
  );

  int          cyc = 0;
  int          n_chk = 0, n_fail = 0;
  int          exp_lo = -1, exp_hi = -1;
  int          wc_err = 0, wc_cyc = 0;
  logic        wc_act = 1'b1;
  logic [19:0] exp_sh = '0;
  logic [1:0]  exp_dd = '0;
  int          edges_since = 0;
  bit          done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // Word clock monitor, sampled 2 ns after each rising edge.
  always @(posedge clk) begin
    logic exp_w;
    #2;
    if (rst_n) begin
      exp_w = !(cyc >= exp_lo && cyc < exp_hi);
      if (wclk !== exp_w) begin
        if (wc_err == 0) begin
          wc_cyc = cyc;
          wc_act = wclk;
        end
        wc_err++;
      end
    end
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  task automatic chk_wclk(input string req);
    chk(wc_err == 0, req, $sformatf("word clock level at cycle %0d", wc_cyc),
        32'(wc_act), 32'(!wc_act));
    wc_err = 0;
  endtask

  // seq[k] is the k-th bit sent. gmode: 0 hold, 1 zero filler, 2 random filler.
  task automatic send_frame(input logic [31:0] seq, input int nbits, input bit bnd,
                            input int gmode, input int gslots, input bit latchk,
                            input string req);
    int          cd;
    bit          valid;
    logic [19:0] new_sh;
    logic [1:0]  new_dd;
    for (int k = 0; k < nbits; k++) begin
      sdat = seq[k];
      wait_n(HALF);
      bclk = ~bclk;
      wait_n(HALF);
    end
    edges_since += nbits;
    wait_n(SLOT);
    for (int i = 0; i < 20; i++) new_sh[i] = seq[i];
    for (int j = 0; j < 2; j++) new_dd[j] = seq[20+j];
    valid = bnd && (edges_since == 24);
    if (bnd) begin
      sdat = ~sdat;
      cd = cyc;
      edges_since = 0;
      if (valid) begin
        exp_lo = cd + LAT + FALL_C;
        exp_hi = exp_lo + LOW_C;
      end
      if (latchk && valid) begin
        wait_n(LAT - 1);
        chk(shared == exp_sh, "R10", "shared before latency", 32'(shared), 32'(exp_sh));
        wait_n(1);
        chk(shared == new_sh, "R10", "shared at latency", 32'(shared), 32'(new_sh));
        wait_n(SLOT - LAT);
      end else begin
        wait_n(SLOT);
      end
      if (valid) begin
        exp_sh = new_sh;
        exp_dd = new_dd;
      end
    end else begin
      wait_n(SLOT);
    end
    for (int g = 0; g < gslots; g++) begin
      if (gmode == 1) sdat = 1'b0;
      else if (gmode == 2) sdat = 1'($urandom % 2);
      wait_n(SLOT);
    end
    chk(shared == exp_sh, req, "shared outputs", 32'(shared), 32'(exp_sh));
    chk(ded == exp_dd, req, "dedicated outputs", 32'(ded), 32'(exp_dd));
    chk_wclk(valid ? "R6" : "R7");
  endtask

  initial begin
    void'($urandom(32'd2024));
    rst_n = 1'b0; en = 1'b0; bclk = 1'b1; sdat = 1'b0;
    wait_n(3);
    rst_n = 1'b1;
    wait_n(5);
    chk(shared == '0, "R1", "shared after reset", 32'(shared), 32'h0);
    chk(ded == '0, "R1", "dedicated after reset", 32'(ded), 32'h0);
    chk(wclk == 1'b1, "R1", "word clock after reset", 32'(wclk), 32'h1);
    en = 1'b1;
    wait_n(2);

    // R2, R10: mapping and latency on a mixed pattern
    send_frame(32'h00B5C3A7, 24, 1'b1, 1, 2, 1'b1, "R2");
    // R2: all ones, including discarded positions
    send_frame(32'h00FFFFFF, 24, 1'b1, 1, 1, 1'b0, "R2");
    // R3: alternating data must not fake a boundary
    send_frame(32'h00555555, 24, 1'b1, 1, 1, 1'b0, "R3");
    send_frame(32'h00AAAAAA, 24, 1'b1, 1, 2, 1'b0, "R3");
    // R8: random filler after the boundary
    send_frame(32'h003C9E61, 24, 1'b1, 2, 4, 1'b0, "R8");
    // R5: short and long words are dropped
    send_frame(32'h00123456, 22, 1'b1, 1, 2, 1'b0, "R5");
    send_frame(32'h03FEDCBA, 26, 1'b1, 1, 2, 1'b0, "R5");
    send_frame(32'h0069F00D, 24, 1'b1, 1, 2, 1'b0, "R4");
    // R7: no boundary, then the following word is over-long
    send_frame(32'h00F0F0F0, 24, 1'b0, 0, 3, 1'b0, "R7");
    send_frame(32'h000F0F0F, 24, 1'b1, 1, 2, 1'b0, "R5");
    send_frame(32'h00C0FFEE, 24, 1'b1, 1, 2, 1'b0, "R4");

    // R9: enable dropped in the middle of a word
    send_frame(32'h000003FF, 10, 1'b0, 0, 0, 1'b0, "R9");
    en = 1'b0;
    edges_since = 0;
    exp_sh = '0;
    exp_dd = '0;
    exp_lo = -1;
    exp_hi = -1;
    wait_n(4);
    chk(shared == '0, "R1", "shared with enable low", 32'(shared), 32'h0);
    chk(ded == '0, "R1", "dedicated with enable low", 32'(ded), 32'h0);
    chk(wclk == 1'b1, "R1", "word clock with enable low", 32'(wclk), 32'h1);
    en = 1'b1;
    wait_n(2);
    send_frame(32'h00D1E2F3, 24, 1'b1, 1, 2, 1'b0, "R9");

    // Random frames, mostly valid, some with the wrong length
    for (int r = 0; r < 30; r++) begin
      int nb;
      int sel;
      sel = int'($urandom % 8);
      nb = (sel == 0) ? 22 : ((sel == 1) ? 26 : 24);
      send_frame($urandom, nb, 1'b1, 1 + int'($urandom % 2),
                 1 + int'($urandom % 3), (sel == 2), (nb == 24) ? "R2" : "R5");
    end

    wait_n(200);
    chk_wclk("R6");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

endmodule